// File: doc/BRIEF.md
# Byte AND Read-Modify-Write Unit

This block executes a byte-wide logical AND whose destination is either an 8-bit half of a 32-bit general register or a byte in memory. The source operand is either an 8-bit immediate or an 8-bit register half. For memory destinations, the byte address comes from one of eight 32-bit pointer registers. Five pointer modes are supported: plain indirect, post-increment, post-decrement, pre-increment and pre-decrement.

The block latches up to three instruction words on `start_i` and decodes them. It then runs the read, the AND and the write-back over a synchronous byte memory port. It also steps the pointer register and updates the condition flags. A loader port lets the surrounding core seed and observe the register file and the flags while the block is idle.

Byte register numbers are 4 bits wide. Bit 3 set selects bits 7:0 of register `n[2:0]`. Bit 3 clear selects bits 15:8 of that register.

Top module: `byte_and_rmw`

## Requirements
- R1: A first word with top nibble 0xE is immediate-to-register. Bits 11:8 are the destination byte register and bits 7:0 are the immediate. Only the addressed byte changes. Every other byte of every register keeps its value.
- R2: A first word with high byte 0x16 is register-to-register. Bits 7:4 are the source byte register and bits 3:0 are the destination byte register.
- R3: A first word of {0x7D, 0, ptr[2:0], 4'hx} selects plain indirect through pointer `ptr`. The second word is either {0xE0, imm} or {0x16, rs, 4'hx}. The memory byte at the pointer address becomes old AND source, and the pointer is unchanged.
- R4: Post-increment and post-decrement read and write the original pointer address. The pointer is then stored plus or minus 1.
- R5: Pre-increment and pre-decrement first store the pointer plus or minus 1, then read and write that updated address.
- R6: When the source register is the low byte of the pointer register, the AND uses that byte as it stands after the pointer update. This holds in every update mode.
- R7: `flags_o` is {H,N,Z,V,C} on bits 4..0. After an operation, N is bit 7 of the result, Z is 1 exactly when the result is 0, and V is 0. H and C keep their previous values.
- R8: Counted from the start edge, `done_o` is high for one cycle on the 2nd edge for a register destination, the 4th for plain indirect, and the 5th for update modes. `busy_o` is high from the start edge until `done_o` rises and is never high together with it.
- R9: An undefined encoding pulses `illegal_o` on the 2nd edge. It changes no register, no flag and no memory byte.
- R10: Each memory operation issues exactly one read and one write, never both in the same cycle. The write comes in the cycle right after the read, and read data is taken one cycle after `mem_re_o`.
- R11: The update-mode encodings are as follows. Immediate forms use first word 0x0174/0x0175/0x0176/0x0177 for post-increment/pre-increment/post-decrement/pre-decrement, then {0x6C, 0, ptr, 4'hx}, then {0xE0, imm}. Register forms use first word 0x0179, then {0x8/0x9/0xA/0xB in the same mode order, 0, ptr, 0x6, rs}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Latch instruction words (accepted only when idle) |
| insn0_i | input | 16 | First instruction word |
| insn1_i | input | 16 | Second instruction word |
| insn2_i | input | 16 | Third instruction word |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle undefined-encoding pulse |
| mem_addr_o | output | REG_W | Byte address |
| mem_re_o | output | 1 | Read strobe |
| mem_we_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the strobe |
| reg_we_i | input | 1 | Loader write of a full register (idle only) |
| reg_idx_i | input | 3 | Loader write index |
| reg_wdata_i | input | REG_W | Loader write data |
| reg_ridx_i | input | 3 | Loader read index |
| reg_rdata_o | output | REG_W | Loader read data (combinational) |
| flags_we_i | input | 1 | Loader flag write (idle only) |
| flags_wdata_i | input | 5 | Loader flag data {H,N,Z,V,C} |
| flags_o | output | 5 | Flags {H,N,Z,V,C} |

## Verification
Register and flag results settle on the 2nd edge after start. Memory results settle on the 4th edge for plain indirect and the 5th for pointer-update modes. `illegal_o` is due on the 2nd edge. The bench drives `start_i` on a falling edge and counts falling edges until `done_o` or `illegal_o` appears, then compares that count with the figure for the form issued. Registers, flags and the memory byte are read only after completion, half a period away from any active edge. Per-operation read and write strobe counts confirm the single access pair.

// File: rtl/band_pkg.sv
package band_pkg;
  localparam int FLG_C = 0;
  localparam int FLG_V = 1;
  localparam int FLG_Z = 2;
  localparam int FLG_N = 3;
  localparam int FLG_H = 4;
  localparam int FLG_W = 5;

  typedef enum logic [2:0] {
    AM_REG, AM_IND, AM_POSTINC, AM_PREINC, AM_POSTDEC, AM_PREDEC
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEC, ST_PRE, ST_READ, ST_WRITE, ST_POST, ST_DONE
  } state_e;

  typedef struct packed {
    logic       legal;
    amode_e     mode;
    logic       src_imm;
    logic [3:0] rs;
    logic [3:0] rd;
    logic [2:0] ptr;
    logic [7:0] imm;
  } dec_t;

  // 2-bit update code shared by both prefix styles
  function automatic amode_e upd_mode(input logic [1:0] code);
    case (code)
      2'd0:    return AM_POSTINC;
      2'd1:    return AM_PREINC;
      2'd2:    return AM_POSTDEC;
      default: return AM_PREDEC;
    endcase
  endfunction
endpackage

// File: rtl/band_decode.sv
module band_decode
  import band_pkg::*;
(
  input  logic [15:0] w0_i,
  input  logic [15:0] w1_i,
  input  logic [15:0] w2_i,
  output dec_t        dec_o
);
  always_comb begin
    dec_o      = '0;
    dec_o.mode = AM_REG;
    if (w0_i[15:12] == 4'hE) begin
      dec_o.legal   = 1'b1;
      dec_o.src_imm = 1'b1;
      dec_o.rd      = w0_i[11:8];
      dec_o.imm     = w0_i[7:0];
    end else if (w0_i[15:8] == 8'h16) begin
      dec_o.legal = 1'b1;
      dec_o.rs    = w0_i[7:4];
      dec_o.rd    = w0_i[3:0];
    end else if (w0_i[15:8] == 8'h7D && !w0_i[7]) begin
      dec_o.mode = AM_IND;
      dec_o.ptr  = w0_i[6:4];
      if (w1_i[15:8] == 8'hE0) begin
        dec_o.legal   = 1'b1;
        dec_o.src_imm = 1'b1;
        dec_o.imm     = w1_i[7:0];
      end else if (w1_i[15:8] == 8'h16) begin
        dec_o.legal = 1'b1;
        dec_o.rs    = w1_i[7:4];
      end
    end else if (w0_i[15:2] == 14'h005D) begin
      dec_o.mode    = upd_mode(w0_i[1:0]);
      dec_o.ptr     = w1_i[6:4];
      dec_o.src_imm = 1'b1;
      dec_o.imm     = w2_i[7:0];
      dec_o.legal   = (w1_i[15:8] == 8'h6C) && !w1_i[7] && (w2_i[15:8] == 8'hE0);
    end else if (w0_i == 16'h0179) begin
      dec_o.mode  = upd_mode(w1_i[13:12]);
      dec_o.ptr   = w1_i[10:8];
      dec_o.rs    = w1_i[3:0];
      dec_o.legal = (w1_i[15:14] == 2'b10) && !w1_i[11] && (w1_i[7:4] == 4'h6);
    end
  end
endmodule

// File: rtl/band_regfile.sv
module band_regfile #(
  parameter  int NREG  = 8,
  parameter  int REG_W = 32,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        full_we_i,
  input  logic [IDX_W-1:0]            full_idx_i,
  input  logic [REG_W-1:0]            full_data_i,
  input  logic                        byte_we_i,
  input  logic [IDX_W:0]              byte_idx_i,
  input  logic [7:0]                  byte_data_i,
  input  logic                        ptr_we_i,
  input  logic [IDX_W-1:0]            ptr_idx_i,
  input  logic [REG_W-1:0]            ptr_data_i,
  output logic [NREG-1:0][REG_W-1:0]  regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_o[g] <= '0;
      end else if (full_we_i && full_idx_i == IDX_W'(g)) begin
        regs_o[g] <= full_data_i;
      end else if (ptr_we_i && ptr_idx_i == IDX_W'(g)) begin
        regs_o[g] <= ptr_data_i;
      end else if (byte_we_i && byte_idx_i[IDX_W-1:0] == IDX_W'(g)) begin
        // index MSB set: low byte, clear: second byte
        if (byte_idx_i[IDX_W]) regs_o[g][7:0]  <= byte_data_i;
        else                   regs_o[g][15:8] <= byte_data_i;
      end
    end
  end
endmodule

// File: rtl/band_logic.sv
module band_logic
  import band_pkg::*;
(
  input  logic [7:0]       a_i,
  input  logic [7:0]       b_i,
  input  logic [FLG_W-1:0] flags_i,
  output logic [7:0]       res_o,
  output logic [FLG_W-1:0] flags_o
);
  always_comb begin
    res_o          = a_i & b_i;
    flags_o        = flags_i;
    flags_o[FLG_N] = res_o[7];
    flags_o[FLG_Z] = (res_o == 8'h00);
    flags_o[FLG_V] = 1'b0;
  end
endmodule

// File: rtl/byte_and_rmw.sv
module byte_and_rmw
  import band_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [15:0]       insn0_i,
  input  logic [15:0]       insn1_i,
  input  logic [15:0]       insn2_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              illegal_o,
  output logic [REG_W-1:0]  mem_addr_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_idx_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic [2:0]        reg_ridx_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              flags_we_i,
  input  logic [4:0]        flags_wdata_i,
  output logic [4:0]        flags_o
);
  localparam int NREG  = 8;
  localparam int IDX_W = $clog2(NREG);

  state_e                     state_q, state_d;
  logic [15:0]                ir0_q, ir1_q, ir2_q;
  logic                       illegal_q;
  logic [REG_W-1:0]           addr_q;
  logic [FLG_W-1:0]           flags_q, flags_new;
  dec_t                       dec;
  logic [NREG-1:0][REG_W-1:0] regs;
  logic [REG_W-1:0]           ptr_val, ptr_step, src_reg;
  logic [7:0]                 src_byte, dst_byte, res;
  logic                       is_pre, is_post, is_inc, idle;

  function automatic logic [7:0] pick(input logic [REG_W-1:0] v, input logic lo);
    return lo ? v[7:0] : v[15:8];
  endfunction

  band_decode u_dec (.w0_i(ir0_q), .w1_i(ir1_q), .w2_i(ir2_q), .dec_o(dec));

  assign idle    = (state_q == ST_IDLE);
  assign is_pre  = (dec.mode == AM_PREINC)  || (dec.mode == AM_PREDEC);
  assign is_post = (dec.mode == AM_POSTINC) || (dec.mode == AM_POSTDEC);
  assign is_inc  = (dec.mode == AM_PREINC)  || (dec.mode == AM_POSTINC);

  assign ptr_val  = regs[dec.ptr];
  assign ptr_step = is_inc ? ptr_val + REG_W'(1) : ptr_val - REG_W'(1);

  // post modes write back after the AND; bypass the stepped pointer
  assign src_reg  = (is_post && dec.rs[IDX_W-1:0] == dec.ptr) ? ptr_step
                                                              : regs[dec.rs[IDX_W-1:0]];
  assign src_byte = dec.src_imm ? dec.imm : pick(src_reg, dec.rs[IDX_W]);
  assign dst_byte = (dec.mode == AM_REG) ? pick(regs[dec.rd[IDX_W-1:0]], dec.rd[IDX_W])
                                         : mem_rdata_i;

  band_logic u_logic (
    .a_i(dst_byte), .b_i(src_byte), .flags_i(flags_q), .res_o(res), .flags_o(flags_new)
  );

  band_regfile #(.NREG(NREG), .REG_W(REG_W)) u_rf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .full_we_i   (reg_we_i && idle),
    .full_idx_i  (reg_idx_i),
    .full_data_i (reg_wdata_i),
    .byte_we_i   (state_q == ST_DEC && dec.legal && dec.mode == AM_REG),
    .byte_idx_i  (dec.rd),
    .byte_data_i (res),
    .ptr_we_i    (state_q == ST_PRE || state_q == ST_POST),
    .ptr_idx_i   (dec.ptr),
    .ptr_data_i  (ptr_step),
    .regs_o      (regs)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_DEC;
      ST_DEC: begin
        if (!dec.legal)              state_d = ST_IDLE;
        else if (dec.mode == AM_REG) state_d = ST_DONE;
        else if (is_pre)             state_d = ST_PRE;
        else                         state_d = ST_READ;
      end
      ST_PRE:   state_d = ST_READ;
      ST_READ:  state_d = ST_WRITE;
      ST_WRITE: state_d = is_post ? ST_POST : ST_DONE;
      ST_POST:  state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ir0_q     <= '0;
      ir1_q     <= '0;
      ir2_q     <= '0;
      illegal_q <= 1'b0;
      addr_q    <= '0;
      flags_q   <= '0;
    end else begin
      state_q   <= state_d;
      illegal_q <= (state_q == ST_DEC) && !dec.legal;
      if (idle && start_i) begin
        ir0_q <= insn0_i;
        ir1_q <= insn1_i;
        ir2_q <= insn2_i;
      end
      if (state_q == ST_READ) addr_q <= ptr_val;
      if (idle && flags_we_i) flags_q <= flags_wdata_i;
      else if ((state_q == ST_DEC && dec.legal && dec.mode == AM_REG) ||
               state_q == ST_WRITE) flags_q <= flags_new;
    end
  end

  assign busy_o      = !idle && (state_q != ST_DONE);
  assign done_o      = (state_q == ST_DONE);
  assign illegal_o   = illegal_q;
  assign mem_re_o    = (state_q == ST_READ);
  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_addr_o  = mem_re_o ? ptr_val : addr_q;
  assign mem_wdata_o = res;
  assign reg_rdata_o = regs[reg_ridx_i];
  assign flags_o     = flags_q;
endmodule

// File: rtl/band_chk.sv
module band_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       done_o,
  input logic       illegal_o,
  input logic       mem_re_o,
  input logic       mem_we_o,
  input logic [7:0] mem_wdata_o,
  input logic [4:0] flags_o
);
  AST_RW_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o)); // R10
  AST_WRITE_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(mem_re_o)); // R10
  AST_N_FROM_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> flags_o[3] == $past(mem_wdata_o[7])); // R7
  AST_Z_FROM_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> flags_o[2] == ($past(mem_wdata_o) == 8'h00)); // R7
  AST_V_CLEAR_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !flags_o[1]); // R7
  AST_CARRY_HALF_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (flags_o[0] == $past(flags_o[0])) && (flags_o[4] == $past(flags_o[4]))); // R7
  AST_BUSY_DONE_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_ILLEGAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !busy_o && !done_o && !mem_we_o); // R9
endmodule

bind byte_and_rmw band_chk i_band_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .illegal_o(illegal_o), .mem_re_o(mem_re_o), .mem_we_o(mem_we_o),
  .mem_wdata_o(mem_wdata_o), .flags_o(flags_o)
);

// File: tb/test_byte_and_rmw.sv
`timescale 1ns/1ps
module test_byte_and_rmw;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] w0 = '0, w1 = '0, w2 = '0;
  logic        busy, done, illegal, mre, mwe;
  logic [31:0] maddr, rdata;
  logic [7:0]  mwdata, mrdata;
  logic        reg_we = 1'b0, flags_we = 1'b0;
  logic [2:0]  reg_idx = '0, reg_ridx = '0;
  logic [31:0] reg_wdata = '0;
  logic [4:0]  flags_wdata = '0, flags;

  int n_chk = 0, n_fail = 0, rd_cnt = 0, wr_cnt = 0;
  logic [7:0]  tb_mem [256];
  logic [7:0]  m_mem  [256];
  logic [31:0] m_rf   [8];
  logic [4:0]  m_flags;

  always #10 clk = ~clk;

  byte_and_rmw i_byte_and_rmw (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .insn0_i(w0), .insn1_i(w1), .insn2_i(w2),
    .busy_o(busy), .done_o(done), .illegal_o(illegal),
    .mem_addr_o(maddr), .mem_re_o(mre), .mem_we_o(mwe),
    .mem_wdata_o(mwdata), .mem_rdata_i(mrdata),
    .reg_we_i(reg_we), .reg_idx_i(reg_idx), .reg_wdata_i(reg_wdata),
    .reg_ridx_i(reg_ridx), .reg_rdata_o(rdata),
    .flags_we_i(flags_we), .flags_wdata_i(flags_wdata), .flags_o(flags)
  );

  always @(posedge clk) begin
    if (mre) begin mrdata <= tb_mem[maddr[7:0]]; rd_cnt <= rd_cnt + 1; end
    if (mwe) begin tb_mem[maddr[7:0]] <= mwdata; wr_cnt <= wr_cnt + 1; end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] getb(input logic [3:0] i);
    return i[3] ? m_rf[i[2:0]][7:0] : m_rf[i[2:0]][15:8];
  endfunction

  task automatic setb(input logic [3:0] i, input logic [7:0] v);
    if (i[3]) m_rf[i[2:0]][7:0] = v; else m_rf[i[2:0]][15:8] = v;
  endtask

  function automatic logic [4:0] nflags(input logic [4:0] f, input logic [7:0] r);
    return {f[4], r[7], r == 8'h00, 1'b0, f[0]};
  endfunction

  task automatic load_reg(input int i, input logic [31:0] v);
    reg_we = 1'b1; reg_idx = 3'(i); reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
    m_rf[i] = v;
  endtask

  task automatic load_all(input int seed);
    for (int i = 0; i < 8; i++)
      load_reg(i, 32'hA5A5A5A5 ^ (32'(seed) * 32'h9E3779B1) ^ (32'(i) * 32'h01020304));
  endtask

  task automatic load_flags(input logic [4:0] f);
    flags_we = 1'b1; flags_wdata = f;
    @(negedge clk);
    flags_we = 1'b0;
    m_flags = f;
  endtask

  task automatic check_state(input string req);
    for (int i = 0; i < 8; i++) begin
      reg_ridx = 3'(i);
      #1;
      chk(req, $sformatf("reg %0d", i), rdata, m_rf[i]);
    end
    chk(req, "flags", 32'(flags), 32'(m_flags));
  endtask

  task automatic run(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c,
                     input int exp_cyc, input logic exp_ill, input int exp_acc, input string req);
    int n;
    rd_cnt = 0; wr_cnt = 0;
    w0 = a; w1 = b; w2 = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!(done || illegal) && n < 20) begin @(negedge clk); n++; end
    chk("R8", {req, " cycles"}, 32'(n), 32'(exp_cyc));
    chk(exp_ill ? "R9" : req, "illegal", 32'(illegal), 32'(exp_ill));
    @(negedge clk);
    chk("R10", "reads", 32'(rd_cnt), 32'(exp_acc));
    chk("R10", "writes", 32'(wr_cnt), 32'(exp_acc));
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      tb_mem[i] = 8'(i * 8'h5B) ^ 8'hA5;
      m_mem[i]  = tb_mem[i];
    end
    for (int i = 0; i < 8; i++) m_rf[i] = '0;
    m_flags = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R8", "busy after reset", 32'(busy), 0);
    chk("R8", "done after reset", 32'(done), 0);
    check_state("R1");

    // R1: immediate to register byte, all destinations
    for (int rd = 0; rd < 16; rd++)
      for (int k = 0; k < 4; k++) begin
        logic [7:0] imm, r;
        imm = 8'h5A + 8'(rd * 8'h11) + 8'(k * 8'h4D);
        if (k == 3) imm = 8'h00;
        load_all(rd * 4 + k);
        load_flags(k[0] ? 5'b10001 : 5'b00010);
        r = getb(4'(rd)) & imm;
        setb(4'(rd), r);
        m_flags = nflags(m_flags, r);
        run({4'hE, 4'(rd), imm}, 16'h0, 16'h0, 2, 1'b0, 0, "R1");
        check_state("R1");
      end

    // R2: register to register, every pair
    for (int rs = 0; rs < 16; rs++)
      for (int rd = 0; rd < 16; rd++) begin
        logic [7:0] r;
        load_all(100 + rs * 16 + rd);
        r = getb(4'(rd)) & getb(4'(rs));
        setb(4'(rd), r);
        m_flags = nflags(m_flags, r);
        run({8'h16, 4'(rs), 4'(rd)}, 16'h0, 16'h0, 2, 1'b0, 0, "R2");
        check_state("R2");
      end

    // R3..R6, R11: memory forms; mode 0 ind,1 post+,2 pre+,3 post-,4 pre-
    for (int mode = 0; mode < 5; mode++)
      for (int p = 0; p < 8; p++)
        for (int v = 0; v < 4; v++) begin
          logic [31:0] pv, np, addr;
          logic [3:0]  rs;
          logic [7:0]  imm, src, r;
          logic [1:0]  code;
          logic [15:0] a, b, c;
          string       req;
          load_all(500 + mode * 32 + p * 4 + v);
          load_flags(v[0] ? 5'b10001 : 5'b01110);
          pv = p[0] ? 32'h000000FF : 32'h00010000 + 32'(v);
          load_reg(p, pv);
          imm = 8'hAA ^ 8'(p * 8'h1F + v);
          rs  = (v == 1) ? {1'b1, 3'(p)} : (v == 2) ? {1'b1, 3'(p + 1)} : {1'b0, 3'(p)};
          code = (mode == 1) ? 2'd0 : (mode == 2) ? 2'd1 : (mode == 3) ? 2'd2 : 2'd3;
          np = (mode == 0) ? pv : (mode == 1 || mode == 2) ? pv + 1 : pv - 1;
          addr = (mode == 2 || mode == 4) ? np : pv;
          m_rf[p] = np;
          src = (v == 0) ? imm : getb(rs);
          r = m_mem[addr[7:0]] & src;
          m_mem[addr[7:0]] = r;
          m_flags = nflags(m_flags, r);
          if (mode == 0) begin
            a = {8'h7D, 1'b0, 3'(p), 4'h0};
            b = (v == 0) ? {8'hE0, imm} : {8'h16, rs, 4'h0};
            c = 16'h0;
          end else if (v == 0) begin
            a = 16'h0174 | 16'(code);
            b = {8'h6C, 1'b0, 3'(p), 4'h8};
            c = {8'hE0, imm};
          end else begin
            a = 16'h0179;
            b = {2'b10, code, 1'b0, 3'(p), 4'h6, rs};
            c = 16'h0;
          end
          req = (v == 1 && mode != 0) ? "R6" : (mode == 0) ? "R3" :
                (mode == 1 || mode == 3) ? "R4" : "R5";
          run(a, b, c, (mode == 0) ? 4 : 5, 1'b0, 1, req);
          check_state(req);
          chk(req, "mem byte", 32'(tb_mem[addr[7:0]]), 32'(m_mem[addr[7:0]]));
          chk("R11", "neighbour byte", 32'(tb_mem[8'(addr[7:0] + 1)]), 32'(m_mem[8'(addr[7:0] + 1)]));
        end

    // R9: undefined encodings change nothing
    load_all(900);
    load_flags(5'b10101);
    for (int k = 0; k < 6; k++) begin
      logic [15:0] a, b;
      int          bad;
      a = (k == 0) ? 16'h0000 : (k == 1) ? 16'h0178 : (k == 2) ? 16'h0179 :
          (k == 3) ? 16'h0174 : (k == 4) ? 16'h7D10 : 16'h7D90;
      b = (k == 2) ? 16'hC069 : (k == 3) ? 16'h6D08 : (k == 4) ? 16'h1234 : 16'hE0FF;
      run(a, b, 16'hE0AA, 2, 1'b1, 0, "R9");
      check_state("R9");
      bad = 0;
      for (int i = 0; i < 256; i++) if (tb_mem[i] !== m_mem[i]) bad++;
      chk("R9", "memory bytes changed", 32'(bad), 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule